// File: doc/BRIEF.md
# Two-Stream Pilot-Trained Channel Estimator and Symbol Detector

This block is the receive core of a noiseless link with two transmit and two receive antennas. Each slot presents one complex sample per receive antenna together with a slot kind. Two pilot slots train the block. In the first, only transmitter A sends, with a pilot value of +1. In the second, only transmitter B sends, with a pilot value of -1. Dividing by the pilot gives the four complex channel coefficients: each one is the received sample, copied as it is or negated.

Once trained, each data slot carries one quadrature phase symbol from each transmitter, mixed through the channel matrix. The detector removes the mixing with the adjugate of the estimated matrix and multiplies by the conjugate of its determinant. This has the same sign as a true inversion and needs no division. It then slices the signs of I and Q back to two bits per stream. A determinant of zero is reported as singular instead of producing a result.

A training sequencer controls when slots are acted on. It has three states: `ST_AWAIT_A` (no coefficients yet), `ST_AWAIT_B` (first half stored) and `ST_READY` (detection allowed). Its transitions are:
- pilot-A in any state goes to `ST_AWAIT_B`, which also covers retraining;
- pilot-B in `ST_AWAIT_B` goes to `ST_READY`;
- pilot-B in `ST_READY` refreshes the second half and stays in `ST_READY`;
- every other slot leaves the state unchanged.

Top module: `mimo_ls_detect`

## Requirements
- R1: While `rst` (active high) is high, the eight coefficient outputs, `sym_valid`, `sym_singular`, `sym_a` and `sym_b` are cleared to zero and the sequencer returns to `ST_AWAIT_A`.
- R2: `slot_kind` encodes 00 idle, 01 pilot from transmitter A, 10 pilot from transmitter B, 11 data. A slot is acted on only at a clock edge where `en` is high. On an edge with `en` low, no coefficient changes.
- R3: An accepted pilot-A slot stores `h_aa = rx1` and `h_ab = rx2`, with both real and imaginary parts copied unchanged.
- R4: An accepted pilot-B slot stores `h_ba = -rx1` and `h_bb = -rx2`. Negation saturates, so -32768 becomes +32767. A pilot-B slot that arrives in `ST_AWAIT_A` is ignored.
- R5: A data slot is accepted only in `ST_READY`. A data slot seen in `ST_AWAIT_A` or `ST_AWAIT_B` produces neither `sym_valid` nor `sym_singular`. A pilot-A slot in `ST_READY` returns the block to `ST_AWAIT_B`.
- R6: With a nonsingular matrix and received samples `rx1 = h_aa·xa + h_ba·xb` and `rx2 = h_ab·xa + h_bb·xb`, the recovered bits equal the sent bits. Each stream's symbol has I in bit 1 and Q in bit 0. A bit is 1 when its component is positive, so 00 is (-,-), 01 is (-,+), 10 is (+,-) and 11 is (+,+).
- R7: A result appears right after the second edge with `en` high that follows the edge accepting the data slot. `sym_valid` is high for one cycle.
- R8: If the determinant `h_aa·h_bb - h_ba·h_ab` is zero, `sym_singular` pulses in place of `sym_valid` and both symbols read 00.
- R9: `sym_valid` and `sym_singular` are never high together.
- R10: A data slot is detected with the coefficients held at the edge that accepted it. Pilot slots that follow while it is in the pipeline do not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Slot and pipeline advance enable |
| slot_kind | input | 2 | 00 idle, 01 pilot A, 10 pilot B, 11 data |
| rx1_re | input | 16 | Receive antenna 1 sample, real |
| rx1_im | input | 16 | Receive antenna 1 sample, imaginary |
| rx2_re | input | 16 | Receive antenna 2 sample, real |
| rx2_im | input | 16 | Receive antenna 2 sample, imaginary |
| h_aa_re | output | 16 | Coefficient, transmitter A to receiver 1, real |
| h_aa_im | output | 16 | Coefficient, transmitter A to receiver 1, imaginary |
| h_ab_re | output | 16 | Coefficient, transmitter A to receiver 2, real |
| h_ab_im | output | 16 | Coefficient, transmitter A to receiver 2, imaginary |
| h_ba_re | output | 16 | Coefficient, transmitter B to receiver 1, real |
| h_ba_im | output | 16 | Coefficient, transmitter B to receiver 1, imaginary |
| h_bb_re | output | 16 | Coefficient, transmitter B to receiver 2, real |
| h_bb_im | output | 16 | Coefficient, transmitter B to receiver 2, imaginary |
| sym_a | output | 2 | Recovered symbol of transmitter A |
| sym_b | output | 2 | Recovered symbol of transmitter B |
| sym_valid | output | 1 | One-cycle strobe for a regular result |
| sym_singular | output | 1 | One-cycle strobe for a result with a zero determinant |

## Verification
The assertions check these properties on every cycle:
- the reset state;
- that coefficients stay frozen while `en` is low;
- that a pilot-A slot copies its samples;
- the exact three-edge path from acceptance to a strobe;
- that the two strobes are exclusive;
- that a singular result reads 00.

Other behaviours can only be shown by the bench's scenarios:
- that the recovered bits match the transmitted bits for many random channels;
- that early data and out-of-order pilots are ignored;
- saturation of the pilot-B negation;
- that a pilot arriving during detection does not disturb the data already in the pipeline.

// File: rtl/mimo_rx_pkg.sv
package mimo_rx_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE    = 2'b00,
        SLOT_PILOT_A = 2'b01,
        SLOT_PILOT_B = 2'b10,
        SLOT_DATA    = 2'b11
    } slot_e;

    typedef enum logic [1:0] {
        ST_AWAIT_A = 2'b00,
        ST_AWAIT_B = 2'b01,
        ST_READY   = 2'b10
    } train_e;

endpackage

// File: rtl/mimo_train_fsm.sv
module mimo_train_fsm
    import mimo_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] slot_kind,
    output logic       ld_a,
    output logic       ld_b,
    output logic       go
);

    train_e st, st_nx;
    slot_e  kind;

    assign kind = slot_e'(slot_kind);

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_AWAIT_A;
        else     st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        if (en) begin
            unique case (kind)
                SLOT_PILOT_A: st_nx = ST_AWAIT_B;
                SLOT_PILOT_B: if (st != ST_AWAIT_A) st_nx = ST_READY;
                default:      st_nx = st;
            endcase
        end
    end

    // outputs
    always_comb begin
        ld_a = 1'b0;
        ld_b = 1'b0;
        go   = 1'b0;
        if (en) begin
            unique case (kind)
                SLOT_PILOT_A: ld_a = 1'b1;
                SLOT_PILOT_B: ld_b = (st != ST_AWAIT_A);
                SLOT_DATA:    go   = (st == ST_READY);
                default:      ;
            endcase
        end
    end

endmodule

// File: rtl/mimo_coef_store.sv
module mimo_coef_store #(
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_a,
    input  logic                 ld_b,
    input  logic signed [SW-1:0] rx1_re,
    input  logic signed [SW-1:0] rx1_im,
    input  logic signed [SW-1:0] rx2_re,
    input  logic signed [SW-1:0] rx2_im,
    output logic signed [SW-1:0] h_aa_re,
    output logic signed [SW-1:0] h_aa_im,
    output logic signed [SW-1:0] h_ab_re,
    output logic signed [SW-1:0] h_ab_im,
    output logic signed [SW-1:0] h_ba_re,
    output logic signed [SW-1:0] h_ba_im,
    output logic signed [SW-1:0] h_bb_re,
    output logic signed [SW-1:0] h_bb_im
);

    localparam logic signed [SW-1:0] MOST_NEG = {1'b1, {(SW-1){1'b0}}};
    localparam logic signed [SW-1:0] MOST_POS = {1'b0, {(SW-1){1'b1}}};

    // division by a pilot of -1, clipped at the one value without a positive twin
    function automatic logic signed [SW-1:0] neg_sat(input logic signed [SW-1:0] v);
        if (v == MOST_NEG) return MOST_POS;
        return -v;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            h_aa_re <= '0; h_aa_im <= '0; h_ab_re <= '0; h_ab_im <= '0;
            h_ba_re <= '0; h_ba_im <= '0; h_bb_re <= '0; h_bb_im <= '0;
        end else begin
            if (ld_a) begin
                h_aa_re <= rx1_re; h_aa_im <= rx1_im;
                h_ab_re <= rx2_re; h_ab_im <= rx2_im;
            end
            if (ld_b) begin
                h_ba_re <= neg_sat(rx1_re); h_ba_im <= neg_sat(rx1_im);
                h_bb_re <= neg_sat(rx2_re); h_bb_im <= neg_sat(rx2_im);
            end
        end
    end

endmodule

// File: rtl/mimo_inv_detect.sv
module mimo_inv_detect #(
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 go,
    input  logic signed [SW-1:0] rx1_re,
    input  logic signed [SW-1:0] rx1_im,
    input  logic signed [SW-1:0] rx2_re,
    input  logic signed [SW-1:0] rx2_im,
    input  logic signed [SW-1:0] h_aa_re,
    input  logic signed [SW-1:0] h_aa_im,
    input  logic signed [SW-1:0] h_ab_re,
    input  logic signed [SW-1:0] h_ab_im,
    input  logic signed [SW-1:0] h_ba_re,
    input  logic signed [SW-1:0] h_ba_im,
    input  logic signed [SW-1:0] h_bb_re,
    input  logic signed [SW-1:0] h_bb_im,
    output logic [1:0]           sym_a,
    output logic [1:0]           sym_b,
    output logic                 sym_valid,
    output logic                 sym_singular
);

    localparam int PW = 2 * SW + 1;   // one complex product component
    localparam int AW = PW + 1;       // difference of two complex products
    localparam int FW = 2 * AW + 1;   // product with conj(det), exact
    localparam int NS = 2;            // spatial streams

    function automatic logic signed [AW-1:0] ext_a(input logic signed [SW-1:0] v);
        return {{(AW-SW){v[SW-1]}}, v};
    endfunction

    function automatic logic signed [FW-1:0] ext_f(input logic signed [AW-1:0] v);
        return {{(FW-AW){v[AW-1]}}, v};
    endfunction

    // (p*q - r*s), complex, real part / imaginary part
    function automatic logic signed [AW-1:0] cdiff_re(
        input logic signed [SW-1:0] pr, pi, qr, qi, rr, ri, sr, si);
        return (ext_a(pr) * ext_a(qr) - ext_a(pi) * ext_a(qi))
             - (ext_a(rr) * ext_a(sr) - ext_a(ri) * ext_a(si));
    endfunction

    function automatic logic signed [AW-1:0] cdiff_im(
        input logic signed [SW-1:0] pr, pi, qr, qi, rr, ri, sr, si);
        return (ext_a(pr) * ext_a(qi) + ext_a(pi) * ext_a(qr))
             - (ext_a(rr) * ext_a(si) + ext_a(ri) * ext_a(sr));
    endfunction

    // stage A: adjugate times received vector, and determinant
    logic signed [AW-1:0] t_re_c [NS];
    logic signed [AW-1:0] t_im_c [NS];
    logic signed [AW-1:0] det_re_c, det_im_c;

    always_comb begin
        t_re_c[0] = cdiff_re(h_bb_re, h_bb_im, rx1_re, rx1_im, h_ba_re, h_ba_im, rx2_re, rx2_im);
        t_im_c[0] = cdiff_im(h_bb_re, h_bb_im, rx1_re, rx1_im, h_ba_re, h_ba_im, rx2_re, rx2_im);
        t_re_c[1] = cdiff_re(h_aa_re, h_aa_im, rx2_re, rx2_im, h_ab_re, h_ab_im, rx1_re, rx1_im);
        t_im_c[1] = cdiff_im(h_aa_re, h_aa_im, rx2_re, rx2_im, h_ab_re, h_ab_im, rx1_re, rx1_im);
        det_re_c  = cdiff_re(h_aa_re, h_aa_im, h_bb_re, h_bb_im, h_ba_re, h_ba_im, h_ab_re, h_ab_im);
        det_im_c  = cdiff_im(h_aa_re, h_aa_im, h_bb_re, h_bb_im, h_ba_re, h_ba_im, h_ab_re, h_ab_im);
    end

    logic                 a_vld;
    logic signed [AW-1:0] t_re_q [NS];
    logic signed [AW-1:0] t_im_q [NS];
    logic signed [AW-1:0] det_re_q, det_im_q;

    // stage B: multiply by conj(det) per stream and take signs
    logic [1:0] bits_c [NS];

    for (genvar g = 0; g < NS; g++) begin : g_stream
        logic signed [FW-1:0] f_re, f_im;
        always_comb begin
            f_re = ext_f(t_re_q[g]) * ext_f(det_re_q) + ext_f(t_im_q[g]) * ext_f(det_im_q);
            f_im = ext_f(t_im_q[g]) * ext_f(det_re_q) - ext_f(t_re_q[g]) * ext_f(det_im_q);
            bits_c[g] = {f_re > 0, f_im > 0};
        end
    end

    logic       b_vld;
    logic       b_sing;
    logic [1:0] b_bits [NS];

    always_ff @(posedge clk) begin
        if (rst) begin
            a_vld    <= 1'b0;
            b_vld    <= 1'b0;
            b_sing   <= 1'b0;
            det_re_q <= '0;
            det_im_q <= '0;
            for (int s = 0; s < NS; s++) begin
                t_re_q[s] <= '0;
                t_im_q[s] <= '0;
                b_bits[s] <= '0;
            end
        end else if (en) begin
            a_vld <= go;
            if (go) begin
                det_re_q <= det_re_c;
                det_im_q <= det_im_c;
                for (int s = 0; s < NS; s++) begin
                    t_re_q[s] <= t_re_c[s];
                    t_im_q[s] <= t_im_c[s];
                end
            end
            b_vld  <= a_vld;
            b_sing <= (det_re_q == '0) && (det_im_q == '0);
            for (int s = 0; s < NS; s++) b_bits[s] <= bits_c[s];
        end
    end

    // output stage
    always_ff @(posedge clk) begin
        if (rst) begin
            sym_a        <= '0;
            sym_b        <= '0;
            sym_valid    <= 1'b0;
            sym_singular <= 1'b0;
        end else begin
            sym_valid    <= en && b_vld && !b_sing;
            sym_singular <= en && b_vld && b_sing;
            if (en && b_vld) begin
                sym_a <= b_sing ? 2'b00 : b_bits[0];
                sym_b <= b_sing ? 2'b00 : b_bits[1];
            end
        end
    end

endmodule

// File: rtl/mimo_ls_detect.sv
module mimo_ls_detect #(
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [1:0]           slot_kind,
    input  logic signed [SW-1:0] rx1_re,
    input  logic signed [SW-1:0] rx1_im,
    input  logic signed [SW-1:0] rx2_re,
    input  logic signed [SW-1:0] rx2_im,
    output logic signed [SW-1:0] h_aa_re,
    output logic signed [SW-1:0] h_aa_im,
    output logic signed [SW-1:0] h_ab_re,
    output logic signed [SW-1:0] h_ab_im,
    output logic signed [SW-1:0] h_ba_re,
    output logic signed [SW-1:0] h_ba_im,
    output logic signed [SW-1:0] h_bb_re,
    output logic signed [SW-1:0] h_bb_im,
    output logic [1:0]           sym_a,
    output logic [1:0]           sym_b,
    output logic                 sym_valid,
    output logic                 sym_singular
);

    logic ld_a, ld_b, go;

    mimo_train_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .slot_kind (slot_kind),
        .ld_a      (ld_a),
        .ld_b      (ld_b),
        .go        (go)
    );

    mimo_coef_store #(.SW(SW)) u_coef (
        .clk     (clk),     .rst     (rst),
        .ld_a    (ld_a),    .ld_b    (ld_b),
        .rx1_re  (rx1_re),  .rx1_im  (rx1_im),
        .rx2_re  (rx2_re),  .rx2_im  (rx2_im),
        .h_aa_re (h_aa_re), .h_aa_im (h_aa_im),
        .h_ab_re (h_ab_re), .h_ab_im (h_ab_im),
        .h_ba_re (h_ba_re), .h_ba_im (h_ba_im),
        .h_bb_re (h_bb_re), .h_bb_im (h_bb_im)
    );

    mimo_inv_detect #(.SW(SW)) u_det (
        .clk          (clk),     .rst     (rst),
        .en           (en),      .go      (go),
        .rx1_re       (rx1_re),  .rx1_im  (rx1_im),
        .rx2_re       (rx2_re),  .rx2_im  (rx2_im),
        .h_aa_re      (h_aa_re), .h_aa_im (h_aa_im),
        .h_ab_re      (h_ab_re), .h_ab_im (h_ab_im),
        .h_ba_re      (h_ba_re), .h_ba_im (h_ba_im),
        .h_bb_re      (h_bb_re), .h_bb_im (h_bb_im),
        .sym_a        (sym_a),
        .sym_b        (sym_b),
        .sym_valid    (sym_valid),
        .sym_singular (sym_singular)
    );

endmodule

// File: rtl/mimo_ls_detect_chk.sv
module mimo_ls_detect_chk #(
    parameter int SW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              go,
    input logic              ld_a,
    input logic [SW-1:0]     rx1_re,
    input logic [SW-1:0]     rx2_im,
    input logic [8*SW-1:0]   hcat,
    input logic [1:0]        sym_a,
    input logic [1:0]        sym_b,
    input logic              sym_valid,
    input logic              sym_singular
);

    // R1: the cycle after reset shows cleared coefficients and strobes
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (hcat == '0 && !sym_valid && !sym_singular && sym_a == 2'b00 && sym_b == 2'b00));

    // R2: an edge with enable low leaves every coefficient alone
    a_r2_hold_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && !$past(rst)) |-> $stable(hcat));

    // R3: an accepted pilot-A slot is copied unchanged
    a_r3_pilot_a_copy: assert property (@(posedge clk) disable iff (rst)
        ($past(ld_a) && !$past(rst)) |->
            (hcat[8*SW-1 -: SW] == $past(rx1_re) && hcat[5*SW-1 -: SW] == $past(rx2_im)));

    // R7: accepted data yields a strobe after two more enabled edges
    a_r7_latency: assert property (@(posedge clk) disable iff (rst)
        ($past(go, 3) && $past(en, 2) && $past(en, 1) && !$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3))
            |-> (sym_valid || sym_singular));

    // R7: strobes only come from an enabled edge
    a_r7_strobe_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (sym_valid || sym_singular) |-> $past(en));

    // R8: singular result reads 00 on both streams
    a_r8_singular_zero: assert property (@(posedge clk) disable iff (rst)
        sym_singular |-> (sym_a == 2'b00 && sym_b == 2'b00));

    // R9: the two strobes exclude each other
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({sym_valid, sym_singular}) <= 1);

endmodule

bind mimo_ls_detect mimo_ls_detect_chk #(.SW(SW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .go           (go),
    .ld_a         (ld_a),
    .rx1_re       (rx1_re),
    .rx2_im       (rx2_im),
    .hcat         ({h_aa_re, h_aa_im, h_ab_re, h_ab_im, h_ba_re, h_ba_im, h_bb_re, h_bb_im}),
    .sym_a        (sym_a),
    .sym_b        (sym_b),
    .sym_valid    (sym_valid),
    .sym_singular (sym_singular)
);

// File: tb/mimo_ls_detect_bench.sv
module mimo_ls_detect_bench;

    localparam int AMP = 4;
    localparam logic [1:0] K_IDLE = 2'b00, K_PA = 2'b01, K_PB = 2'b10, K_DATA = 2'b11;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, en;
    logic [1:0] slot_kind;
    logic signed [15:0] rx1_re, rx1_im, rx2_re, rx2_im;
    logic signed [15:0] h_aa_re, h_aa_im, h_ab_re, h_ab_im;
    logic signed [15:0] h_ba_re, h_ba_im, h_bb_re, h_bb_im;
    logic [1:0] sym_a, sym_b;
    logic sym_valid, sym_singular;

    mimo_ls_detect u_mimo_ls_detect (
        .clk(clk), .rst(rst), .en(en), .slot_kind(slot_kind),
        .rx1_re(rx1_re), .rx1_im(rx1_im), .rx2_re(rx2_re), .rx2_im(rx2_im),
        .h_aa_re(h_aa_re), .h_aa_im(h_aa_im), .h_ab_re(h_ab_re), .h_ab_im(h_ab_im),
        .h_ba_re(h_ba_re), .h_ba_im(h_ba_im), .h_bb_re(h_bb_re), .h_bb_im(h_bb_im),
        .sym_a(sym_a), .sym_b(sym_b), .sym_valid(sym_valid), .sym_singular(sym_singular)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // channel model held by the bench
    int caa_r, caa_i, cab_r, cab_i, cba_r, cba_i, cbb_r, cbb_i;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick(input logic [1:0] k, input logic e, input int a, input int b, input int c, input int d);
        @(negedge clk);
        slot_kind = k; en = e;
        rx1_re = a[15:0]; rx1_im = b[15:0]; rx2_re = c[15:0]; rx2_im = d[15:0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(K_IDLE, 1'b1, 0, 0, 0, 0);
    endtask

    function automatic int comp(input logic b);
        return b ? AMP : -AMP;
    endfunction

    task automatic make_y(input logic [1:0] sa, input logic [1:0] sb,
                          output int y1r, output int y1i, output int y2r, output int y2i);
        int ar, ai, br, bi;
        ar = comp(sa[1]); ai = comp(sa[0]); br = comp(sb[1]); bi = comp(sb[0]);
        y1r = caa_r*ar - caa_i*ai + cba_r*br - cba_i*bi;
        y1i = caa_r*ai + caa_i*ar + cba_r*bi + cba_i*br;
        y2r = cab_r*ar - cab_i*ai + cbb_r*br - cbb_i*bi;
        y2i = cab_r*ai + cab_i*ar + cbb_r*bi + cbb_i*br;
    endtask

    function automatic bit det_zero();
        int dr, di;
        dr = (caa_r*cbb_r - caa_i*cbb_i) - (cba_r*cab_r - cba_i*cab_i);
        di = (caa_r*cbb_i + caa_i*cbb_r) - (cba_r*cab_i + cba_i*cab_r);
        return (dr == 0) && (di == 0);
    endfunction

    function automatic int rnd();
        return int'($urandom_range(4000)) - 2000;
    endfunction

    task automatic rand_h();
        do begin
            caa_r = rnd(); caa_i = rnd(); cab_r = rnd(); cab_i = rnd();
            cba_r = rnd(); cba_i = rnd(); cbb_r = rnd(); cbb_i = rnd();
        end while (det_zero());
    endtask

    task automatic train();
        tick(K_PA, 1'b1, caa_r, caa_i, cab_r, cab_i);
        tick(K_PB, 1'b1, -cba_r, -cba_i, -cbb_r, -cbb_i);
    endtask

    task automatic run_data(input logic [1:0] sa, input logic [1:0] sb, input bit sing);
        int y1r, y1i, y2r, y2i;
        make_y(sa, sb, y1r, y1i, y2r, y2i);
        tick(K_DATA, 1'b1, y1r, y1i, y2r, y2i);
        idle(2);
        chk("R7 no strobe after one edge", int'(sym_valid | sym_singular), 0);
        idle(1);
        if (!sing) begin
            chk("R7 valid after two edges", int'(sym_valid), 1);
            chk("R6 stream A bits", int'(sym_a), int'(sa));
            chk("R6 stream B bits", int'(sym_b), int'(sb));
        end else begin
            chk("R8 singular strobe", int'(sym_singular), 1);
            chk("R9 no valid with singular", int'(sym_valid), 0);
            chk("R8 symbols zero", int'({sym_a, sym_b}), 0);
        end
        idle(1);
        chk("R7 one-cycle strobe", int'(sym_valid | sym_singular), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int y1r, y1i, y2r, y2i;
        void'($urandom(32'd2024));
        rst = 1'b1; en = 1'b0; slot_kind = K_IDLE;
        rx1_re = '0; rx1_im = '0; rx2_re = '0; rx2_im = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 coefficients cleared", int'({h_aa_re, h_ab_im, h_ba_re, h_bb_im} != 0), 0);
        chk("R1 strobes cleared", int'({sym_valid, sym_singular, sym_a, sym_b}), 0);

        // R5 data before any training is ignored
        rand_h();
        make_y(2'b11, 2'b00, y1r, y1i, y2r, y2i);
        tick(K_DATA, 1'b1, y1r, y1i, y2r, y2i);
        for (int i = 0; i < 4; i++) begin
            idle(1);
            chk("R5 early data ignored", int'(sym_valid | sym_singular), 0);
        end

        // R4 pilot B before pilot A is ignored
        tick(K_PB, 1'b1, 500, 600, 700, 800);
        idle(1);
        chk("R4 early pilot B ignored", int'(h_ba_re), 0);

        // R2 disabled pilot A has no effect
        tick(K_PA, 1'b0, 123, 45, 67, 89);
        idle(1);
        chk("R2 disabled slot ignored", int'(h_aa_re), 0);

        // R5 data after pilot A only is still ignored
        caa_r = 300; caa_i = -200; cab_r = 150; cab_i = 400;
        cba_r = -250; cba_i = 100; cbb_r = 350; cbb_i = -50;
        tick(K_PA, 1'b1, caa_r, caa_i, cab_r, cab_i);
        tick(K_DATA, 1'b1, 1000, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            idle(1);
            chk("R5 half-trained data ignored", int'(sym_valid | sym_singular), 0);
        end

        // R3 R4 directed training
        train();
        idle(1);
        chk("R3 h_aa real", int'(h_aa_re), 300);
        chk("R3 h_ab imag", int'(h_ab_im), 400);
        chk("R4 h_ba real", int'(h_ba_re), -250);
        chk("R4 h_bb imag", int'(h_bb_im), -50);

        // R6 R7 every symbol pair on a fixed channel
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                run_data(a[1:0], b[1:0], 1'b0);

        // R6 random channels and symbols
        for (int t = 0; t < 24; t++) begin
            rand_h();
            train();
            for (int j = 0; j < 6; j++)
                run_data(2'($urandom_range(3)), 2'($urandom_range(3)), 1'b0);
        end

        // R7 enable pause stretches latency in enabled edges
        make_y(2'b01, 2'b10, y1r, y1i, y2r, y2i);
        tick(K_DATA, 1'b1, y1r, y1i, y2r, y2i);
        tick(K_IDLE, 1'b0, 0, 0, 0, 0);
        tick(K_IDLE, 1'b0, 0, 0, 0, 0);
        tick(K_IDLE, 1'b1, 0, 0, 0, 0);
        tick(K_IDLE, 1'b1, 0, 0, 0, 0);
        chk("R7 paused not yet valid", int'(sym_valid), 0);
        tick(K_IDLE, 1'b1, 0, 0, 0, 0);
        chk("R7 paused valid", int'(sym_valid), 1);
        chk("R6 paused stream A", int'(sym_a), 1);
        chk("R6 paused stream B", int'(sym_b), 2);

        // R10 retraining right behind a data slot
        make_y(2'b10, 2'b11, y1r, y1i, y2r, y2i);
        tick(K_DATA, 1'b1, y1r, y1i, y2r, y2i);
        rand_h();
        train();
        tick(K_IDLE, 1'b1, 0, 0, 0, 0);
        chk("R10 in-flight valid", int'(sym_valid), 1);
        chk("R10 in-flight stream A", int'(sym_a), 2);
        chk("R10 in-flight stream B", int'(sym_b), 3);
        run_data(2'b00, 2'b01, 1'b0);

        // R5 pilot A in ready state forces retraining
        tick(K_PA, 1'b1, caa_r, caa_i, cab_r, cab_i);
        make_y(2'b11, 2'b11, y1r, y1i, y2r, y2i);
        tick(K_DATA, 1'b1, y1r, y1i, y2r, y2i);
        for (int i = 0; i < 4; i++) begin
            idle(1);
            chk("R5 data during retrain ignored", int'(sym_valid | sym_singular), 0);
        end

        // R4 saturating negation
        tick(K_PB, 1'b1, -32768, 5, 0, -32768);
        idle(1);
        chk("R4 saturated h_ba real", int'(h_ba_re), 32767);
        chk("R4 h_ba imag negated", int'(h_ba_im), -5);
        chk("R4 saturated h_bb imag", int'(h_bb_im), 32767);

        // R8 R9 singular channel
        caa_r = 100; caa_i = 50; cab_r = -30; cab_i = 70;
        cba_r = 100; cba_i = 50; cbb_r = -30; cbb_i = 70;
        train();
        run_data(2'b10, 2'b01, 1'b1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule